// File: doc/BRIEF.md
# Gain and Offset Trim Datapath

This block corrects each sample headed for a 14-bit string converter. A raw input code is scaled by a programmable gain coefficient and then moved by a programmable offset coefficient. The result is clamped into the converter's unsigned code range and registered for the converter data register. The block only computes. Whatever sits upstream holds the coefficients, so the block stores nothing for software.

The gain applied is (m' + 2) / 16384, where m' is the gain code with its least significant bit cleared. The gain code 0x3FFE therefore scales by exactly one, and 0x1FFE scales by one half. The offset code carries a bias of 8192, so 0x2000 leaves the sample unshifted. A one-bit valid travels alongside the data through two register stages, and a new sample is accepted on every clock.

Top module: `trim_corr`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid` is 0 and `x2_out` is 0.
- R2: `out_valid` is high exactly two clock edges after a cycle in which `in_valid` was high, and low two edges after a cycle in which it was low.
- R3: Bit 0 of `m_in` has no effect on the output. Gain codes that differ only in that bit give the same `x2_out`.
- R4: With `m_in` = 0x3FFE (or 0x3FFF) and `c_in` = 0x2000, the output equals `x1_in`.
- R5: In general `x2_out` = floor(((m_in with bit 0 cleared) + 2) * x1_in / 16384) + c_in - 8192, computed with a product of at least 29 bits.
- R6: When that sum exceeds 16383, `x2_out` is 16383.
- R7: When that sum is negative, `x2_out` is 0.
- R8: Samples given on consecutive cycles each produce their own result on consecutive cycles, with no sample lost.
- R9: In a cycle where `out_valid` is low, `x2_out` keeps the value of the last valid result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The input sample is present this cycle |
| x1_in | input | 14 | Raw input code |
| m_in | input | 14 | Gain coefficient (bit 0 ignored) |
| c_in | input | 14 | Offset coefficient, biased by 8192 |
| out_valid | output | 1 | `x2_out` holds a new result |
| x2_out | output | 14 | Corrected, clamped code |

## Verification
The hardest cases to reach are the two clamp edges, because they depend on the gain product and the offset together. A small gain combined with the most negative offset must reach zero. A full gain on a large code combined with the largest offset must reach 16383. The stimulus sets these coefficient pairs on purpose and places codes on both sides of each crossing point. It also sends gain codes that differ only in bit 0, and mixes back-to-back samples with gaps, so that the hold behaviour and the two-cycle alignment are checked against a queue model on every clock.

// File: rtl/trim_pkg.sv
package trim_pkg;
  localparam int CODE_W = 14;
endpackage

// File: rtl/trim_gain_stage.sv
module trim_gain_stage #(
  parameter int DW = trim_pkg::CODE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic [DW-1:0]        x1,
  input  logic [DW-1:0]        m,
  input  logic [DW-1:0]        c,
  output logic                 out_vld,
  output logic [DW:0]          quo,
  output logic signed [DW:0]   off
);
  localparam int GW = DW + 1;
  localparam int PW = GW + DW;
  localparam logic signed [DW:0] BIAS = (DW+1)'(1 << (DW-1));

  logic [GW-1:0] gain_eff;
  logic [PW-1:0] prod;
  logic signed [DW:0] off_nxt;

  always_comb begin
    gain_eff = {1'b0, m[DW-1:1], 1'b0} + GW'(2);
    prod     = PW'(gain_eff) * PW'(x1);
    off_nxt  = $signed({1'b0, c}) - BIAS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      quo     <= '0;
      off     <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        quo <= prod[PW-1:DW];
        off <= off_nxt;
      end
    end
  end

  // R8: each accepted sample advances one stage on the next edge
  a_r8_stage_adv: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld);
  // R8: no spurious sample appears in the stage
  a_r8_no_bubble_fill: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld);
endmodule

// File: rtl/trim_offset_stage.sv
module trim_offset_stage #(
  parameter int DW = trim_pkg::CODE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic [DW:0]          quo,
  input  logic signed [DW:0]   off,
  output logic                 out_vld,
  output logic [DW-1:0]        x2
);
  localparam int SW = DW + 2;
  localparam logic signed [SW-1:0] MAXV = SW'((1 << DW) - 1);

  logic signed [SW-1:0] sum;
  logic [DW-1:0] x2_nxt;

  always_comb begin
    sum = $signed({1'b0, quo}) + SW'(off);
    if (sum < 0)
      x2_nxt = '0;
    else if (sum > MAXV)
      x2_nxt = '1;
    else
      x2_nxt = sum[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      x2      <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) x2 <= x2_nxt;
    end
  end

  // R7: the most negative offset with a small quotient clamps to zero
  a_r7_floor: assert property (@(posedge clk) disable iff (rst)
    (in_vld && off == -(1 <<< (DW-1)) && quo < (1 << (DW-1))) |=> (x2 == '0));
  // R6: the largest offset with a quotient in the upper half clamps to full scale
  a_r6_ceiling: assert property (@(posedge clk) disable iff (rst)
    (in_vld && off == ((1 <<< (DW-1)) - 1) && quo >= (1 << (DW-1))) |=> (x2 == '1));
  // R9: the output only moves when a result is delivered
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> $stable(x2));
endmodule

// File: rtl/trim_corr.sv
module trim_corr #(
  parameter int DW = trim_pkg::CODE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] x1_in,
  input  logic [DW-1:0] m_in,
  input  logic [DW-1:0] c_in,
  output logic          out_valid,
  output logic [DW-1:0] x2_out
);
  logic                s1_vld;
  logic [DW:0]         s1_quo;
  logic signed [DW:0]  s1_off;

  trim_gain_stage #(.DW(DW)) u_gain (
    .clk(clk), .rst(rst), .in_vld(in_valid), .x1(x1_in), .m(m_in), .c(c_in),
    .out_vld(s1_vld), .quo(s1_quo), .off(s1_off)
  );

  trim_offset_stage #(.DW(DW)) u_offs (
    .clk(clk), .rst(rst), .in_vld(s1_vld), .quo(s1_quo), .off(s1_off),
    .out_vld(out_valid), .x2(x2_out)
  );

  // R2: a valid input shows up two edges later
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);
  // R2: an idle input cycle gives an idle output cycle
  a_r2_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 !out_valid);
  // R4: unity gain and zero offset pass the code straight through
  a_r4_identity: assert property (@(posedge clk) disable iff (rst)
    (in_valid && m_in[DW-1:1] == '1 && c_in == DW'(1 << (DW-1)))
      |-> ##2 (x2_out == $past(x1_in, 2)));
endmodule

// File: tb/trim_corr_test.sv
module trim_corr_test;
  logic clk = 0;
  logic rst = 1;
  logic in_valid = 0;
  logic [13:0] x1_in = '0, m_in = 14'h3FFE, c_in = 14'h2000;
  logic out_valid;
  logic [13:0] x2_out;

  always #5 clk = ~clk;

  trim_corr uut (.clk(clk), .rst(rst), .in_valid(in_valid), .x1_in(x1_in),
                 .m_in(m_in), .c_in(c_in), .out_valid(out_valid), .x2_out(x2_out));

  typedef struct { bit v; int x; } exp_t;
  exp_t q[$];
  int tests = 0, fails = 0, last_x = 0, cyc = 0;
  string cur_req = "R5";
  bit done = 0;

  function automatic int model(int x1, int m, int c);
    int g, s;
    g = (m & 'h3FFE) + 2;
    s = ((g * x1) >>> 14) + c - 8192;
    if (s < 0) s = 0;
    if (s > 16383) s = 16383;
    return s;
  endfunction

  always @(posedge clk) begin
    if (rst) q.delete();
    else begin
      exp_t e;
      e.v = in_valid;
      e.x = model(int'(x1_in), int'(m_in), int'(c_in));
      q.push_back(e);
      if (q.size() > 4) void'(q.pop_front());
    end
  end

  always @(negedge clk) begin
    if (!rst && q.size() >= 2 && !done) begin
      exp_t e;
      e = q[q.size()-2];
      tests++;
      if (out_valid !== e.v) begin
        fails++;
        $display("FAIL %s (R2) out_valid=%0d expected %0d", cur_req, out_valid, e.v);
      end
      tests++;
      if (e.v) begin
        if (int'(x2_out) != e.x) begin
          fails++;
          $display("FAIL %s x2_out=%0d expected %0d", cur_req, x2_out, e.x);
        end
        last_x = e.x;
      end else if (int'(x2_out) != last_x) begin
        fails++;
        $display("FAIL R9 x2_out=%0d expected held %0d", x2_out, last_x);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic put(input bit v, input int x, input int m, input int c);
    @(negedge clk);
    in_valid = v; x1_in = 14'(x); m_in = 14'(m); c_in = 14'(c);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    tests++;
    if (out_valid !== 1'b0 || x2_out !== 14'd0) begin
      fails++;
      $display("FAIL R1 out_valid=%0d x2_out=%0d expected 0 0", out_valid, x2_out);
    end
    @(negedge clk); rst = 0;
    tests++;
    if (out_valid !== 1'b0 || x2_out !== 14'd0) begin
      fails++;
      $display("FAIL R1 after release out_valid=%0d x2_out=%0d expected 0 0", out_valid, x2_out);
    end
    // R4: identity with default coefficients, including the end codes
    cur_req = "R4";
    put(1, 0, 'h3FFE, 'h2000); put(1, 16383, 'h3FFE, 'h2000);
    put(1, 8192, 'h3FFF, 'h2000); put(1, 1234, 'h3FFE, 'h2000);
    // R8: back-to-back samples with differing gains
    cur_req = "R8";
    for (int i = 0; i < 32; i++) put(1, i * 511, 'h2FFE - i * 64, 'h2000 + i);
    // R3: gain codes differing only in bit 0
    cur_req = "R3";
    for (int i = 0; i < 8; i++) begin
      put(1, 9000 + i, 'h1FFE, 'h2100);
      put(1, 9000 + i, 'h1FFF, 'h2100);
    end
    // R6: high clamp on both sides of the crossing
    cur_req = "R6";
    put(1, 16383, 'h3FFE, 'h3FFF); put(1, 8192, 'h3FFE, 'h3FFF);
    put(1, 8191, 'h3FFE, 'h3FFF); put(1, 8193, 'h3FFE, 'h3FFF);
    // R7: low clamp on both sides of the crossing
    cur_req = "R7";
    put(1, 100, 'h0FFE, 'h0000); put(1, 16383, 'h1FFE, 'h0000);
    put(1, 16383, 'h3FFE, 'h0000); put(1, 5, 'h3FFE, 'h1FFA);
    put(1, 5, 'h3FFE, 'h1FFB);
    // R2 and R9: gaps between samples, inputs wiggling while idle
    cur_req = "R2";
    for (int i = 0; i < 40; i++)
      put(i % 3 == 0, $urandom_range(0, 16383), $urandom_range(0, 16383), $urandom_range(0, 16383));
    // R5: random coefficients and codes
    cur_req = "R5";
    for (int i = 0; i < 300; i++)
      put($urandom_range(0, 3) != 0, $urandom_range(0, 16383), $urandom_range(0, 16383), $urandom_range(0, 16383));
    put(0, 0, 0, 0);
    repeat (4) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule